// File: doc/BRIEF.md
# Boot Memory Remap Decoder

This block decodes every access on a 32-bit system bus into a chip select and a translated word address for one of two on-chip memories. One is a 64 KB flash organised as 16-bit halfwords. The other is an 8 KB SRAM organised as 32-bit words. Each memory has a fixed physical window. In addition, one of the two is aliased into a mirror window at the bottom of the map, where the exception vectors (0x00000000 to 0x00000020) are fetched. A one-bit control register selects the aliased memory. When the bit is clear, flash is mirrored. When it is set, SRAM is mirrored, so exception handlers can run from the faster 32-bit memory.

Every reset clears the bit and returns flash to address zero. The chip combines all of its reset sources onto `rst_n`. Software changes the bit by writing the control register, and each new setting governs accesses accepted after the write.

Requests use a valid/ready handshake. Every accepted request produces exactly one registered response cycle. Unmapped addresses are flagged with an error and raise no chip select. Writes to the mirror window are also flagged when it holds flash. The memory arrays, the flash programming logic and the processor are outside this block.

Top module: `bootmap_decoder`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `rsp_valid`, `flash_cs` and `sram_cs` are 0, and the remap bit reads back as 0.
- R2: With the remap bit clear, an address below 0x00010000 selects flash with `flash_we`=0. `flash_addr` is address bits [15:1].
- R3: An address in 0x00080000..0x0008FFFF selects flash with `flash_addr` = (address − 0x00080000)>>1, whatever the remap bit. A write there raises `flash_cs` and `flash_we` without error.
- R4: An address in 0x00010000..0x00011FFF selects SRAM with `sram_addr` = (address − 0x00010000)>>2, for reads and writes, whatever the remap bit.
- R5: With the remap bit set, an address below 0x00002000 selects SRAM with `sram_addr` = address>>2. This applies to reads and writes. An address from 0x00002000 to 0x0000FFFF gives `rsp_err`=1 and no chip select.
- R6: A read in the vector range 0x00000000..0x00000020 is served by flash when the bit is clear and by SRAM when it is set.
- R7: A write below 0x00010000 while the bit is clear gives `rsp_err`=1 with `flash_cs`=0, `flash_we`=0 and `sram_cs`=0.
- R8: The control register at 0xFFFF0220 returns the remap bit in `rsp_rdata` bit 0, with bits 31:1 zero. A write stores only write-data bit 0, and the rest of the word is ignored. A register access raises no chip select and no error.
- R9: An access accepted in the cycle after the register write is decoded with the new bit. The register write itself completes under the old mapping.
- R10: Any other address gives `rsp_err`=1 with both chip selects low. Examples are 0x00012000, 0x00090000 and 0x40000000.
- R11: Asserting `rst_n` after the bit was set returns flash to the mirror window.
- R12: `req_ready` is 1 out of reset. `rsp_valid` is 1 exactly in the cycle after each accepted request and 0 otherwise. In that cycle, `rsp_rdata`, `flash_addr` and `sram_addr` are zero unless they carry a register read or a selected memory.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Combined active-low reset, asynchronous |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response cycle for the request accepted one cycle earlier |
| rsp_err | output | 1 | Decode error |
| rsp_rdata | output | 32 | Control-register read data |
| flash_cs | output | 1 | Flash chip select |
| flash_we | output | 1 | Flash write enable |
| flash_addr | output | 15 | Flash halfword index |
| sram_cs | output | 1 | SRAM chip select |
| sram_we | output | 1 | SRAM write enable |
| sram_addr | output | 11 | SRAM word index |
| mem_wdata | output | 32 | Write data forwarded to the memories |

## Verification
Each result of this block is due one clock edge after the request is accepted. The remap register update is the exception: it affects the request accepted at the following edge. The bench drives a request on a falling edge. It compares the complete response word (valid, error, selects, enables, both indices and read data) on the next falling edge, half a cycle after the registered outputs change. To exercise R9, a register write and a memory read are issued back to back. The bench checks the write's response and then, one cycle later, the read's response.

// File: rtl/bootmap_pkg.sv
package bootmap_pkg;
   typedef enum logic [1:0] {
      RGN_NONE  = 2'd0,
      RGN_FLASH = 2'd1,
      RGN_SRAM  = 2'd2,
      RGN_CTRL  = 2'd3
   } rgn_e;

   typedef struct packed {
      rgn_e        rgn;
      logic        err;
      logic [31:0] offset;
   } dec_t;
endpackage

// File: rtl/bootmap_remap_reg.sv
module bootmap_remap_reg (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_en,
   input  logic wr_bit,
   output logic remap
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     remap <= 1'b0;
      else if (wr_en) remap <= wr_bit;
   end
endmodule

// File: rtl/bootmap_region_dec.sv
module bootmap_region_dec
   import bootmap_pkg::*;
#(
   parameter logic [31:0] LOW_LIMIT   = 32'h0001_0000,
   parameter logic [31:0] SRAM_BASE   = 32'h0001_0000,
   parameter logic [31:0] SRAM_BYTES  = 32'h0000_2000,
   parameter logic [31:0] FLASH_BASE  = 32'h0008_0000,
   parameter logic [31:0] FLASH_BYTES = 32'h0001_0000,
   parameter logic [31:0] CTRL_ADDR   = 32'hFFFF_0220
) (
   input  logic [31:0] addr,
   input  logic        write,
   input  logic        remap,
   output dec_t        dec
);
   localparam logic [31:0] SRAM_END  = SRAM_BASE + SRAM_BYTES;
   localparam logic [31:0] FLASH_END = FLASH_BASE + FLASH_BYTES;

   always_comb begin
      dec = '{rgn: RGN_NONE, err: 1'b1, offset: 32'd0};
      if (addr == CTRL_ADDR) begin
         dec = '{rgn: RGN_CTRL, err: 1'b0, offset: 32'd0};
      end else if (addr < LOW_LIMIT) begin
         if (remap) begin
            if (addr < SRAM_BYTES)
               dec = '{rgn: RGN_SRAM, err: 1'b0, offset: addr};
         end else if (!write && addr < FLASH_BYTES) begin
            dec = '{rgn: RGN_FLASH, err: 1'b0, offset: addr};
         end
      end else if (addr >= SRAM_BASE && addr < SRAM_END) begin
         dec = '{rgn: RGN_SRAM, err: 1'b0, offset: addr - SRAM_BASE};
      end else if (addr >= FLASH_BASE && addr < FLASH_END) begin
         dec = '{rgn: RGN_FLASH, err: 1'b0, offset: addr - FLASH_BASE};
      end
   end
endmodule

// File: rtl/bootmap_xlate.sv
module bootmap_xlate #(
   parameter int unsigned BYTES      = 65536,
   parameter int unsigned WORD_BYTES = 2,
   localparam int unsigned SHIFT     = $clog2(WORD_BYTES),
   localparam int unsigned AW        = $clog2(BYTES) - SHIFT
) (
   input  logic [31:0]   offset,
   output logic [AW-1:0] index
);
   assign index = AW'(offset >> SHIFT);
endmodule

// File: rtl/bootmap_decoder.sv
module bootmap_decoder
   import bootmap_pkg::*;
#(
   parameter logic [31:0] LOW_LIMIT        = 32'h0001_0000,
   parameter logic [31:0] SRAM_BASE        = 32'h0001_0000,
   parameter int unsigned SRAM_BYTES       = 8192,
   parameter int unsigned SRAM_WORD_BYTES  = 4,
   parameter logic [31:0] FLASH_BASE       = 32'h0008_0000,
   parameter int unsigned FLASH_BYTES      = 65536,
   parameter int unsigned FLASH_WORD_BYTES = 2,
   parameter logic [31:0] CTRL_ADDR        = 32'hFFFF_0220,
   localparam int unsigned FAW = $clog2(FLASH_BYTES) - $clog2(FLASH_WORD_BYTES),
   localparam int unsigned SAW = $clog2(SRAM_BYTES) - $clog2(SRAM_WORD_BYTES)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           req_valid,
   output logic           req_ready,
   input  logic           req_write,
   input  logic [31:0]    req_addr,
   input  logic [31:0]    req_wdata,
   output logic           rsp_valid,
   output logic           rsp_err,
   output logic [31:0]    rsp_rdata,
   output logic           flash_cs,
   output logic           flash_we,
   output logic [FAW-1:0] flash_addr,
   output logic           sram_cs,
   output logic           sram_we,
   output logic [SAW-1:0] sram_addr,
   output logic [31:0]    mem_wdata
);
   // elaboration-time parameter checks
   if ((SRAM_BYTES & (SRAM_BYTES - 1)) != 0 || (FLASH_BYTES & (FLASH_BYTES - 1)) != 0)
      begin : g_bad_size
         $error("memory sizes must be powers of two");
      end
   if (LOW_LIMIT > SRAM_BASE || LOW_LIMIT > FLASH_BASE) begin : g_bad_low
      $error("mirror window overlaps a physical window");
   end
   if (FLASH_BYTES > LOW_LIMIT || SRAM_BYTES > LOW_LIMIT) begin : g_bad_fit
      $error("memory larger than the mirror window");
   end

   logic accept;
   logic remap_q;
   dec_t dec;
   logic [FAW-1:0] f_idx;
   logic [SAW-1:0] s_idx;

   assign req_ready = 1'b1;
   assign accept    = req_valid && req_ready;

   bootmap_region_dec #(
      .LOW_LIMIT  (LOW_LIMIT),
      .SRAM_BASE  (SRAM_BASE),
      .SRAM_BYTES (32'(SRAM_BYTES)),
      .FLASH_BASE (FLASH_BASE),
      .FLASH_BYTES(32'(FLASH_BYTES)),
      .CTRL_ADDR  (CTRL_ADDR)
   ) dec_i (
      .addr (req_addr),
      .write(req_write),
      .remap(remap_q),
      .dec  (dec)
   );

   bootmap_remap_reg reg_i (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (accept && req_write && dec.rgn == RGN_CTRL),
      .wr_bit(req_wdata[0]),
      .remap (remap_q)
   );

   // one translator per memory, differing only in geometry
   for (genvar m = 0; m < 2; m++) begin : g_xl
      if (m == 0) begin : g_flash
         bootmap_xlate #(.BYTES(FLASH_BYTES), .WORD_BYTES(FLASH_WORD_BYTES))
            xl_i (.offset(dec.offset), .index(f_idx));
      end else begin : g_sram
         bootmap_xlate #(.BYTES(SRAM_BYTES), .WORD_BYTES(SRAM_WORD_BYTES))
            xl_i (.offset(dec.offset), .index(s_idx));
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid  <= 1'b0;
         rsp_err    <= 1'b0;
         rsp_rdata  <= '0;
         flash_cs   <= 1'b0;
         flash_we   <= 1'b0;
         flash_addr <= '0;
         sram_cs    <= 1'b0;
         sram_we    <= 1'b0;
         sram_addr  <= '0;
         mem_wdata  <= '0;
      end else begin
         rsp_valid  <= accept;
         rsp_err    <= accept && dec.err;
         rsp_rdata  <= (accept && !req_write && dec.rgn == RGN_CTRL) ? {31'd0, remap_q} : 32'd0;
         flash_cs   <= accept && dec.rgn == RGN_FLASH;
         flash_we   <= accept && dec.rgn == RGN_FLASH && req_write;
         flash_addr <= (accept && dec.rgn == RGN_FLASH) ? f_idx : '0;
         sram_cs    <= accept && dec.rgn == RGN_SRAM;
         sram_we    <= accept && dec.rgn == RGN_SRAM && req_write;
         sram_addr  <= (accept && dec.rgn == RGN_SRAM) ? s_idx : '0;
         mem_wdata  <= accept ? req_wdata : 32'd0;
      end
   end
endmodule

// File: rtl/bootmap_decoder_chk.sv
module bootmap_decoder_chk #(
   parameter logic [31:0] LOW_LIMIT  = 32'h0001_0000,
   parameter int unsigned SRAM_BYTES = 8192,
   parameter logic [31:0] CTRL_ADDR  = 32'hFFFF_0220
) (
   input logic        clk,
   input logic        rst_n,
   input logic        req_valid,
   input logic        req_write,
   input logic [31:0] req_addr,
   input logic [31:0] req_wdata,
   input logic        remap,
   input logic        rsp_valid,
   input logic        rsp_err,
   input logic        flash_cs,
   input logic        sram_cs
);
   assert_rsp_follows_R12: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   assert_no_spurious_rsp_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);
   assert_single_select_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({flash_cs, sram_cs}) && !(rsp_err && (flash_cs || sram_cs)));
   assert_flash_mirror_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_write && req_addr < LOW_LIMIT && !remap |=> rsp_err && !flash_cs);
   assert_sram_mirror_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && remap && req_addr < LOW_LIMIT && req_addr >= 32'(SRAM_BYTES)
      |=> rsp_err && !sram_cs);
   assert_remap_update_R9: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_write && req_addr == CTRL_ADDR |=> remap == $past(req_wdata[0]));
endmodule

bind bootmap_decoder bootmap_decoder_chk #(
   .LOW_LIMIT (LOW_LIMIT),
   .SRAM_BYTES(SRAM_BYTES),
   .CTRL_ADDR (CTRL_ADDR)
) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .req_valid(req_valid),
   .req_write(req_write),
   .req_addr (req_addr),
   .req_wdata(req_wdata),
   .remap    (remap_q),
   .rsp_valid(rsp_valid),
   .rsp_err  (rsp_err),
   .flash_cs (flash_cs),
   .sram_cs  (sram_cs)
);

// File: tb/bootmap_decoder_tb_top.sv
`timescale 1ns/1ps
module bootmap_decoder_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic [31:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic        rsp_valid, rsp_err, flash_cs, flash_we, sram_cs, sram_we;
   logic [31:0] rsp_rdata, mem_wdata;
   logic [14:0] flash_addr;
   logic [10:0] sram_addr;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   localparam logic [31:0] CTRL = 32'hFFFF_0220;

   always #2.5 clk = ~clk;

   bootmap_decoder dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
      .flash_cs(flash_cs), .flash_we(flash_we), .flash_addr(flash_addr),
      .sram_cs(sram_cs), .sram_we(sram_we), .sram_addr(sram_addr),
      .mem_wdata(mem_wdata)
   );

   // response word: valid, err, fcs, fwe, scs, swe, faddr, saddr, rdata
   function automatic logic [63:0] pack_rsp(bit v, bit e, bit fc, bit fw, bit sc, bit sw,
                                            logic [14:0] fa, logic [10:0] sa, logic [31:0] rd);
      return {v, e, fc, fw, sc, sw, fa, sa, rd};
   endfunction

   function automatic logic [63:0] actual();
      return pack_rsp(rsp_valid, rsp_err, flash_cs, flash_we, sram_cs, sram_we,
                      flash_addr, sram_addr, rsp_rdata);
   endfunction

   function automatic logic [63:0] x_flash(bit wr, logic [14:0] idx);
      return pack_rsp(1, 0, 1, wr, 0, 0, idx, 0, 0);
   endfunction
   function automatic logic [63:0] x_sram(bit wr, logic [10:0] idx);
      return pack_rsp(1, 0, 0, 0, 1, wr, 0, idx, 0);
   endfunction
   function automatic logic [63:0] x_err();
      return pack_rsp(1, 1, 0, 0, 0, 0, 0, 0, 0);
   endfunction
   function automatic logic [63:0] x_reg(logic [31:0] rd);
      return pack_rsp(1, 0, 0, 0, 0, 0, 0, 0, rd);
   endfunction

   task automatic check(string tag, logic [63:0] exp);
      n_run++;
      if (actual() !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, actual(), exp);
      end
   endtask

   task automatic drive(bit wr, logic [31:0] a, logic [31:0] d);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
   endtask

   // one request; the response is sampled a full cycle later, at the falling edge
   task automatic access(string tag, bit wr, logic [31:0] a, logic [31:0] d, logic [63:0] exp);
      @(negedge clk); drive(wr, a, d);
      @(negedge clk); req_valid = 1'b0;
      check(tag, exp);
   endtask

   task automatic set_remap(bit v);
      access("R8 reg write", 1, CTRL, {31'd0, v}, x_reg(0));
   endtask

   task automatic t_reset();
      @(negedge clk);
      check("R1 outputs in reset", pack_rsp(0, 0, 0, 0, 0, 0, 0, 0, 0));
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 idle after reset", pack_rsp(0, 0, 0, 0, 0, 0, 0, 0, 0));
      n_run++;
      if (req_ready !== 1'b1) begin
         n_fail++; $display("FAIL R12 req_ready: actual %b expected 1", req_ready);
      end
      access("R1 remap reads 0", 0, CTRL, 0, x_reg(0));
   endtask

   task automatic t_flash_mirror();
      access("R2 low read", 0, 32'h0000_1234, 0, x_flash(0, 15'h091A));
      access("R2 top of window", 0, 32'h0000_FFFE, 0, x_flash(0, 15'h7FFF));
      access("R6 vector flash", 0, 32'h0000_0018, 0, x_flash(0, 15'h000C));
      access("R7 mirror write rejected", 1, 32'h0000_0100, 32'h55, x_err());
   endtask

   task automatic t_physical();
      access("R3 flash phys", 0, 32'h0008_0010, 0, x_flash(0, 15'h0008));
      access("R3 flash phys end", 0, 32'h0008_FFFE, 0, x_flash(0, 15'h7FFF));
      access("R3 flash phys write", 1, 32'h0008_0004, 32'h1, x_flash(1, 15'h0002));
      access("R4 sram phys", 0, 32'h0001_0008, 0, x_sram(0, 11'h002));
      access("R4 sram phys end", 0, 32'h0001_1FFC, 0, x_sram(0, 11'h7FF));
      access("R4 sram phys write", 1, 32'h0001_0100, 32'h2, x_sram(1, 11'h040));
   endtask

   task automatic t_unmapped();
      access("R10 above sram", 0, 32'h0001_2000, 0, x_err());
      access("R10 above flash", 0, 32'h0009_0000, 0, x_err());
      access("R10 far", 1, 32'h4000_0000, 0, x_err());
   endtask

   task automatic t_reg_bits();
      access("R8 upper bits ignored", 1, CTRL, 32'hFFFF_FFFE, x_reg(0));
      access("R8 readback 0", 0, CTRL, 0, x_reg(0));
      access("R8 write 3", 1, CTRL, 32'h0000_0003, x_reg(0));
      access("R8 readback 1", 0, CTRL, 0, x_reg(1));
   endtask

   task automatic t_back_to_back();
      set_remap(0);
      @(negedge clk); drive(1, CTRL, 32'h1);
      @(negedge clk); drive(0, 32'h0000_0000, 0);
      check("R9 reg write response", x_reg(0));
      @(negedge clk); req_valid = 1'b0;
      check("R9 next access uses sram", x_sram(0, 11'h000));
      @(negedge clk);
      check("R12 idle no response", pack_rsp(0, 0, 0, 0, 0, 0, 0, 0, 0));
   endtask

   task automatic t_sram_mirror();
      access("R6 vector sram", 0, 32'h0000_0018, 0, x_sram(0, 11'h006));
      access("R6 vector top sram", 0, 32'h0000_0020, 0, x_sram(0, 11'h008));
      access("R5 sram mirror end", 0, 32'h0000_1FFC, 0, x_sram(0, 11'h7FF));
      access("R5 beyond sram size", 0, 32'h0000_2000, 0, x_err());
      access("R5 sram mirror write", 1, 32'h0000_0040, 32'h9, x_sram(1, 11'h010));
      access("R3 flash phys with remap", 0, 32'h0008_0010, 0, x_flash(0, 15'h0008));
   endtask

   task automatic t_reset_restores();
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      access("R11 remap cleared", 0, CTRL, 0, x_reg(0));
      access("R11 flash mirrored", 0, 32'h0000_0004, 0, x_flash(0, 15'h0002));
   endtask

   initial begin
      t_reset();
      t_flash_mirror();
      t_physical();
      t_unmapped();
      t_reg_bits();
      t_back_to_back();
      t_sram_mirror();
      t_reset_restores();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule